// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block reorders byte channels within a time-division multiplexed frame of 32 slots. Each clock cycle carries one channel byte. A strobe marks slot 0 of every frame. Every captured byte is written into data storage. For every output slot the block looks up a per-channel connection entry. That entry either names a source slot whose stored byte is forwarded, or carries a fixed message byte supplied by a host processor.

Each connection entry has an 8-bit low part and a 4-bit control part. The control part holds four bits:

- Message versus switched operation.
- Shortest-path versus frame-aligned delay.
- A per-channel output enable.
- A level for a side control line that accompanies each slot.

An active-low global disable input forces every slot off, whatever the per-channel enables say. The output enable is reported as a flag and is not a real tri-state pin.

The host reaches the entries through a small register port. A page bit in a control register selects which half of an entry the host sees. The low address pins select the channel.

Top module: `tsi_switch`

## Requirements
- R1: After reset, out_byte, out_oe, out_ctl and cpu_rdata are 0. Every connection entry is cleared, which means switched, shortest-path, disabled, source 0 and side bit 0. All stored bytes are 0.
- R2: A cycle with frame_start high carries input slot 0, and the slots that follow count up modulo 32. The output for slot o appears in the cycle that carries input slot o. Its entry is read one cycle earlier, so a host write made in that cycle takes effect only from the next frame.
- R3: With the message bit set (control bit 1), out_byte during slot o equals the entry's low byte, and it repeats every frame until the byte is rewritten.
- R4: In shortest-path mode (control bit 2 clear), a switched slot reads its source index from low bits 4:0. When the forward distance d = (o - s) mod 32 is 3 or more, the byte appears d cycles after capture, including cases that wrap across the frame boundary (for example 30 to 1).
- R5: In shortest-path mode with d of 0, 1 or 2, the byte appears d + 32 cycles after capture, which is in the next frame.
- R6: In frame-aligned mode (control bit 2 set), output slot o of frame f carries source slot s as captured in frame f-1, for every pair of s and o.
- R7: When control bit 0 of a slot's entry is clear, out_oe is low for that whole slot.
- R8: While oe_all_n is low, out_oe is low in every slot, regardless of the entries.
- R9: out_ctl during slot o equals control bit 3 of that slot's entry.
- R10: When cpu_addr[5] is 1, the access goes to the control register, whose bit 0 is the page. When cpu_addr[5] is 0, it goes to channel cpu_addr[4:0]. Page 0 reaches the low byte, and page 1 reaches the control bits {side, frame-aligned, message, enable} in data bits 3:0.
- R11: A read (cpu_sel high, cpu_wr low) shows the addressed value on cpu_rdata in the next cycle. The value is the last one written, with unused upper bits at 0. cpu_rdata holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per channel time |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | High in the cycle that carries slot 0 |
| in_byte | input | 8 | Incoming channel byte for the current slot |
| oe_all_n | input | 1 | Active-low global output disable |
| cpu_sel | input | 1 | Host access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Bit 5 selects the control register, bits 4:0 select the channel |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data, registered |
| out_byte | output | 8 | Outgoing byte for the current slot |
| out_oe | output | 1 | Output drive enable for the current slot |
| out_ctl | output | 1 | Per-slot side control level |

## Verification
The bench checks every output slot, so a wrong slot counter or parity bit misplaces bytes in the very next cycle. A parity error shows within one frame, as bytes from the wrong frame in frame-aligned channels. A corrupted stored byte or connection entry reappears in the matching slot of every later frame, so it surfaces within 32 cycles of the fault. Two errors show up on the first slot whose source sits at distance 0 to 3: wrong capture-to-store forwarding, and an off-by-one in the fetch lead. Both cost a whole frame or a single cycle of delay there.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;

    // Per-channel control bits, host bit order 3..0
    typedef struct packed {
        logic ctl;   // side control line level
        logic cdly;  // frame-aligned (constant) delay
        logic msg;   // message byte instead of switched data
        logic oe;    // output enable for the slot
    } chan_ctrl_t;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/tsi_slot_timer.sv
`timescale 1ns/1ps
// Tracks the current slot and frame parity, and the slot fetched one ahead.
module tsi_slot_timer #(
    parameter int N = 32,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic [SW-1:0] cur_slot,
    output logic          cur_par,
    output logic [SW-1:0] fetch_slot,
    output logic          fetch_par
);

    localparam logic [SW-1:0] LAST = SW'(N - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic          par;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        cur_slot   = (frame_start || st_q.slot == LAST) ? '0 : st_q.slot + 1'b1;
        cur_par    = (cur_slot == '0) ? ~st_q.par : st_q.par;
        fetch_slot = (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
        fetch_par  = (fetch_slot == '0) ? ~cur_par : cur_par;
        st_d.slot  = cur_slot;
        st_d.par   = cur_par;
    end

    // Reset state makes the first cycle slot 0 of an even frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{slot: LAST, par: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsi_data_store.sv
`timescale 1ns/1ps
// Captured byte storage: one shortest-path array and two frame banks.
module tsi_data_store #(
    parameter int N  = 32,
    parameter int DW = 8,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cur_slot,
    input  logic          cur_par,
    input  logic [DW-1:0] in_byte,
    input  logic [SW-1:0] var_addr,
    input  logic [SW-1:0] cst_addr,
    input  logic          cst_par,
    output logic [DW-1:0] var_data,
    output logic [DW-1:0] cst_data
);

    typedef struct packed {
        logic          vld;
        logic          par;
        logic [SW-1:0] slot;
        logic [DW-1:0] data;
    } cap_t;

    cap_t          cap_d, cap_q;
    logic [DW-1:0] vmem_d [N];
    logic [DW-1:0] vmem_q [N];
    logic [DW-1:0] bank_d [2][N];
    logic [DW-1:0] bank_q [2][N];

    // Capture register, then write one cycle later into both stores
    always_comb begin
        cap_d.vld  = 1'b1;
        cap_d.par  = cur_par;
        cap_d.slot = cur_slot;
        cap_d.data = in_byte;
        vmem_d     = vmem_q;
        bank_d     = bank_q;
        if (cap_q.vld) begin
            vmem_d[cap_q.slot]            = cap_q.data;
            bank_d[cap_q.par][cap_q.slot] = cap_q.data;
        end
    end

    // Shortest-path read sees only completed writes (three-slot minimum).
    // Frame-aligned read forwards the two newest bytes of the closing frame.
    always_comb begin
        var_data = vmem_q[var_addr];
        if (cap_q.vld && cap_q.par == cst_par && cap_q.slot == cst_addr) begin
            cst_data = cap_q.data;
        end else if (cur_par == cst_par && cur_slot == cst_addr) begin
            cst_data = in_byte;
        end else begin
            cst_data = bank_q[cst_par][cst_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            for (int i = 0; i < N; i++) begin
                vmem_q[i]    <= '0;
                bank_q[0][i] <= '0;
                bank_q[1][i] <= '0;
            end
        end else begin
            cap_q  <= cap_d;
            vmem_q <= vmem_d;
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/tsi_connect_store.sv
`timescale 1ns/1ps
// Connection entries with paged host access and a fetch read port.
module tsi_connect_store
    import tsi_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 8,
    localparam int SW = $clog2(N),
    localparam int AW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_sel,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic [SW-1:0] fetch_slot,
    output chan_ctrl_t    fe_ctrl,
    output logic [DW-1:0] fe_low
);

    typedef struct packed {
        logic          page;
        logic [DW-1:0] rdata;
    } hreg_t;

    hreg_t         r_d, r_q;
    logic [DW-1:0] lo_d [N];
    logic [DW-1:0] lo_q [N];
    chan_ctrl_t    hi_d [N];
    chan_ctrl_t    hi_q [N];
    logic [SW-1:0] ch;
    logic          is_reg;

    assign ch     = cpu_addr[SW-1:0];
    assign is_reg = cpu_addr[AW-1];

    always_comb begin
        r_d  = r_q;
        lo_d = lo_q;
        hi_d = hi_q;
        if (cpu_sel && cpu_wr) begin
            if (is_reg) begin
                r_d.page = cpu_wdata[0];
            end else if (r_q.page) begin
                hi_d[ch] = chan_ctrl_t'(cpu_wdata[CTRL_W-1:0]);
            end else begin
                lo_d[ch] = cpu_wdata;
            end
        end
        if (cpu_sel && !cpu_wr) begin
            if (is_reg) begin
                r_d.rdata = {{(DW-1){1'b0}}, r_q.page};
            end else if (r_q.page) begin
                r_d.rdata = {{(DW-CTRL_W){1'b0}}, hi_q[ch]};
            end else begin
                r_d.rdata = lo_q[ch];
            end
        end
    end

    assign cpu_rdata = r_q.rdata;
    assign fe_ctrl   = hi_q[fetch_slot];
    assign fe_low    = lo_q[fetch_slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < N; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else begin
            r_q  <= r_d;
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
// Time-slot interchange: N slots per frame, one byte per cycle.
// N must be a power of two; DW must hold a slot index and the control bits.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 8,
    localparam int SW = $clog2(N),
    localparam int AW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [DW-1:0] in_byte,
    input  logic          oe_all_n,
    input  logic          cpu_sel,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic [DW-1:0] out_byte,
    output logic          out_oe,
    output logic          out_ctl
);

    logic [SW-1:0] cur_slot, fetch_slot, src;
    logic          cur_par, fetch_par;
    chan_ctrl_t    fe_ctrl;
    logic [DW-1:0] fe_low, var_data, cst_data;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          oe;
        logic          ctl;
    } ostage_t;

    ostage_t os_d, os_q;

    tsi_slot_timer #(.N(N)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cur_slot   (cur_slot),
        .cur_par    (cur_par),
        .fetch_slot (fetch_slot),
        .fetch_par  (fetch_par)
    );

    tsi_connect_store #(.N(N), .DW(DW)) u_cm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .fetch_slot(fetch_slot),
        .fe_ctrl   (fe_ctrl),
        .fe_low    (fe_low)
    );

    assign src = fe_low[SW-1:0];

    // Frame-aligned reads take the bank of the frame before the fetched slot
    tsi_data_store #(.N(N), .DW(DW)) u_dm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_slot(cur_slot),
        .cur_par (cur_par),
        .in_byte (in_byte),
        .var_addr(src),
        .cst_addr(src),
        .cst_par (~fetch_par),
        .var_data(var_data),
        .cst_data(cst_data)
    );

    // Output stage loads one slot ahead of transmission
    always_comb begin
        if (fe_ctrl.msg) begin
            os_d.data = fe_low;
        end else if (fe_ctrl.cdly) begin
            os_d.data = cst_data;
        end else begin
            os_d.data = var_data;
        end
        os_d.oe  = fe_ctrl.oe;
        os_d.ctl = fe_ctrl.ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign out_byte = os_q.data;
    assign out_oe   = os_q.oe & oe_all_n;
    assign out_ctl  = os_q.ctl;

endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          oe_all_n,
    input logic          cpu_sel,
    input logic          cpu_wr,
    input logic [DW-1:0] cpu_rdata,
    input logic [DW-1:0] out_byte,
    input logic          out_oe,
    input logic          out_ctl,
    input chan_ctrl_t    fe_ctrl,
    input logic [DW-1:0] fe_low
);

    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    // R3: a fetched message entry puts its low byte out in the next slot
    a_r3_msg_out: assert property (@(posedge clk) disable iff (!rst_n)
        started && $past(fe_ctrl.msg) |-> out_byte == $past(fe_low));

    // R7: a fetched disabled entry keeps the slot undriven
    a_r7_chan_off: assert property (@(posedge clk) disable iff (!rst_n)
        started && !$past(fe_ctrl.oe) |-> !out_oe);

    // R8: global disable wins
    a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_all_n |-> !out_oe);

    // R9: side line follows the fetched entry
    a_r9_ctl_follow: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> out_ctl == $past(fe_ctrl.ctl));

    // R11: read data only changes after a read access
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        started && !$past(cpu_sel && !cpu_wr) |-> $stable(cpu_rdata));

endmodule

bind tsi_switch tsi_switch_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_all_n (oe_all_n),
    .cpu_sel  (cpu_sel),
    .cpu_wr   (cpu_wr),
    .cpu_rdata(cpu_rdata),
    .out_byte (out_byte),
    .out_oe   (out_oe),
    .out_ctl  (out_ctl),
    .fe_ctrl  (fe_ctrl),
    .fe_low   (fe_low)
);

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;

    localparam int N  = 32;
    localparam int DW = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_start;
    logic [DW-1:0] in_byte;
    logic          oe_all_n;
    logic          cpu_sel, cpu_wr;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata, out_byte;
    logic          out_oe, out_ctl;

    always #2.5 clk = ~clk;

    tsi_switch #(.N(N), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_byte(in_byte),
        .oe_all_n(oe_all_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .out_byte(out_byte),
        .out_oe(out_oe), .out_ctl(out_ctl)
    );

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    logic [7:0] hist [0:8191];
    logic [7:0] m_lo [N];
    logic [3:0] m_hi [N];
    logic       m_page;
    logic [7:0] c_lo [N];
    logic [3:0] c_hi [N];
    logic [7:0] e_byte, e_rd;
    logic       e_oe, e_ctl;
    string      e_tag;
    logic       glob_n;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // One channel time: drive, check, predict next slot, update host model
    task automatic step(input bit w, input bit r, input logic [AW-1:0] a, input logic [7:0] d);
        logic [7:0] ib;
        logic [3:0] h;
        int o, s, dd, dl, t, f;
        string otag;
        ib = 8'((cyc * 73 + 19 + (cyc / N) * 5) & 255);
        hist[cyc]   = ib;
        in_byte     = ib;
        frame_start = (cyc % N == 0);
        oe_all_n    = glob_n;
        cpu_sel     = w | r;
        cpu_wr      = w;
        cpu_addr    = a;
        cpu_wdata   = d;
        #1;
        if (cyc == 0) otag = "R1 reset oe";
        else if (!glob_n) otag = "R8 global off";
        else if (!e_oe) otag = "R7 channel off";
        else otag = "R7 channel on";
        chk(e_tag, int'(out_byte), int'(e_byte));
        chk(otag, int'(out_oe), int'(e_oe & glob_n));
        chk((cyc == 0) ? "R1 reset ctl" : "R9 side bit", int'(out_ctl), int'(e_ctl));
        chk((cyc == 0) ? "R1 reset rdata" : "R10 R11 host read", int'(cpu_rdata), int'(e_rd));
        o = (cyc + 1) % N;
        h = m_hi[o];
        s = int'(m_lo[o][4:0]);
        e_oe  = h[0];
        e_ctl = h[3];
        if (h[1]) begin
            e_byte = m_lo[o];
            e_tag  = $sformatf("R2 R3 message slot %0d", o);
        end else if (h[2]) begin
            f = (cyc + 1) / N;
            e_byte = (f == 0) ? 8'h00 : hist[(f - 1) * N + s];
            e_tag  = $sformatf("R2 R6 frame-aligned slot %0d src %0d", o, s);
        end else begin
            dd = (o - s + N) % N;
            dl = (dd >= 3) ? dd : dd + N;
            t  = cyc + 1 - dl;
            e_byte = (t < 0) ? 8'h00 : hist[t];
            e_tag  = (dd >= 3) ? $sformatf("R2 R4 slot %0d src %0d", o, s)
                               : $sformatf("R2 R5 slot %0d src %0d", o, s);
        end
        if (r) begin
            if (a[AW-1]) e_rd = {7'd0, m_page};
            else if (m_page) e_rd = {4'd0, m_hi[a[4:0]]};
            else e_rd = m_lo[a[4:0]];
        end
        if (w) begin
            if (a[AW-1]) m_page = d[0];
            else if (m_page) m_hi[a[4:0]] = d[3:0];
            else m_lo[a[4:0]] = d;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
    endtask

    task automatic program_all();
        step(1'b1, 1'b0, 6'h20, 8'h01);
        for (int o = 0; o < N; o++) step(1'b1, 1'b0, 6'(o), {4'h0, c_hi[o]});
        step(1'b1, 1'b0, 6'h20, 8'h00);
        for (int o = 0; o < N; o++) step(1'b1, 1'b0, 6'(o), c_lo[o]);
    endtask

    initial begin
        glob_n = 1'b1;
        m_page = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
        e_byte = '0; e_rd = '0; e_oe = 1'b0; e_ctl = 1'b0;
        e_tag = "R1 reset byte";
        rst_n = 1'b0; frame_start = 1'b0; in_byte = '0; oe_all_n = 1'b1;
        cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: cleared entries run for over a frame
        run(40);
        // R4 R5: shortest-path sweeps, distances (3o+p) mod 32
        for (int p = 0; p < 6; p++) begin
            for (int o = 0; o < N; o++) begin
                c_hi[o] = {4'(((o + p) % 2) << 3) | 4'b0001};
                c_lo[o] = 8'((o - ((o * 3 + p) % N) + N) % N);
            end
            program_all();
            run(64);
        end
        // R6: frame-aligned sweeps
        for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < N; o++) begin
                c_hi[o] = {4'(((o + p) % 2) << 3) | 4'b0101};
                c_lo[o] = 8'((o * 7 + p * 13) % N);
            end
            program_all();
            run(64);
        end
        // Mixed modes: message, switched, frame-aligned, disabled message
        for (int o = 0; o < N; o++) begin
            case (o % 4)
                0: begin c_hi[o] = 4'b0011; c_lo[o] = 8'(8'h40 + o * 3); end
                1: begin c_hi[o] = 4'b1001; c_lo[o] = 8'((o + 17) % N); end
                2: begin c_hi[o] = 4'b1101; c_lo[o] = 8'((o + 17) % N); end
                default: begin c_hi[o] = 4'b0010; c_lo[o] = 8'(8'h90 + o); end
            endcase
        end
        program_all();
        run(40);
        // R2: write in the fetch cycle of slot 8 (next frame), early write for slot 12
        while (cyc % N != 7) run(1);
        step(1'b1, 1'b0, 6'd8, 8'hC3);
        while (cyc % N != 10) run(1);
        step(1'b1, 1'b0, 6'd12, 8'h5A);
        run(70);
        // R8: global disable
        glob_n = 1'b0;
        run(40);
        glob_n = 1'b1;
        run(40);
        // R10 R11: read back everything
        step(1'b0, 1'b1, 6'h20, '0);
        for (int o = 0; o < N; o++) step(1'b0, 1'b1, 6'(o), '0);
        step(1'b1, 1'b0, 6'h20, 8'h01);
        step(1'b0, 1'b1, 6'h20, '0);
        for (int o = 0; o < N; o++) step(1'b0, 1'b1, 6'(o), '0);
        run(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule